// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple single-request port inside the chip and an external asynchronous static RAM of 262,144 four-bit words. The RAM has three active-low strobes (chip select, write strobe and read-drive enable) and a bidirectional 4-bit data bus. The controller accepts one read or one write at a time. It registers the 18-bit address and the write data and then generates the strobe sequence. It times each phase in whole clock cycles, rounding up nanosecond timing parameters. When the access finishes it raises a one-cycle completion pulse, and for reads it presents the captured data with that pulse.

The data bus is split at the block boundary into an outgoing value, a drive-enable and an incoming value, so the pad-level tri-state buffer stays outside. The controller turns its driver on only while the RAM's outputs are guaranteed off. It keeps the read-drive enable high for the whole of every write. After a read it inserts an idle turnaround cycle before the next write. A write is the overlap of chip select and write strobe. Both rise on the same clock edge, and the address and data are then held for one more cycle so that the zero-hold requirement is met with margin.

The state machine has six states. IDLE is the only state that accepts a request. RD_ACC holds the read strobes for the access time. RD_RESP returns data. TURN is the bus turnaround cycle. WR_PULSE is the write overlap. WR_HOLD is the post-write hold cycle. The transitions are:
- IDLE to RD_ACC on a read request.
- IDLE to WR_PULSE on a write request when the last access was not a read.
- IDLE to TURN on a write request when the last access was a read.
- TURN to WR_PULSE.
- RD_ACC to RD_RESP when its timer expires.
- WR_PULSE to WR_HOLD when its timer expires.
- RD_RESP and WR_HOLD back to IDLE.

Top module: `asram_ctrl`

## Requirements
- R1: During and directly after reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and op_done are 0, and req_ready is 1.
- R2: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC cycles. RD_CYC is max(read cycle, address access, select access, enable access) divided by the clock period, rounded up, with a minimum of 1; this gives 2 at the default values. mem_dq_i is sampled on the last edge of that phase, and op_done rises one clock later with op_rdata equal to the word stored at the address. From the accepting edge, op_done is seen RD_CYC+1 cycles later.
- R3: A write holds mem_ce_n=0 and mem_we_n=0 together for WR_CYC cycles. WR_CYC is max(write cycle, write pulse, select-to-end, data setup) divided by the clock period, rounded up, with a minimum of 1; this gives 2 at the default values. Both strobes rise on the same edge, and the word on mem_dq_o at that moment is stored. One hold cycle follows with the strobes high, mem_dq_oe still 1 and the address and data unchanged. op_done is 1 in that hold cycle, WR_CYC+1 cycles after acceptance.
- R4: mem_oe_n is 1 whenever mem_ce_n and mem_we_n are both 0, and mem_dq_oe is 1 only while mem_oe_n is 1.
- R5: A write whose previous access was a read first spends one turnaround cycle with all strobes high and mem_dq_oe=0. Its op_done therefore comes WR_CYC+2 cycles after acceptance.
- R6: req_ready is 1 only in IDLE. A request with req_valid=1 while req_ready=0 is ignored and does not change the RAM contents. op_done lasts exactly one cycle.
- R7: mem_addr equals the accepted request address and does not change while mem_ce_n is 0.
- R8: Every address from 0 through 18'h3FFFF reaches mem_addr unchanged, and words at both ends of the range are stored and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | 4 | Read data, valid with op_done after a read |
| mem_addr | output | 18 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM read-drive enable, active low |
| mem_dq_o | output | 4 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 4 | Data from the RAM pads |

## Verification
A state register that is stuck or skips a state shows up at the ports within one or two cycles. The symptoms are a strobe overlap with the wrong length, op_done arriving early or late, the data driver enabled while the RAM may be driving, or req_ready held high during an access. A phase timer loaded with the wrong count changes the completion latency of the very next access, so the bench measures latency on every operation. A lost turnaround cycle or a corrupted address latch stays hidden until a later read of the affected word. For that reason the random traffic reads back addresses that were written earlier, and the checker watches the address and the driver on every cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_RESP,
        ST_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_t;

    // Round a time up to whole clocks, never less than one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_req_latch.sv
module asram_req_latch #(
    parameter int AW = 18,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_wdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_wdata <= '0;
        end else if (capture) begin
            out_addr  <= in_addr;
            out_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/asram_rdata_reg.sv
module asram_rdata_reg #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (capture)
            q <= d;
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 4,
    parameter int T_CLK_NS = 8,
    parameter int T_RC_NS  = 12,
    parameter int T_AA_NS  = 12,
    parameter int T_ACE_NS = 12,
    parameter int T_DOE_NS = 6,
    parameter int T_WC_NS  = 12,
    parameter int T_PWE_NS = 10,
    parameter int T_SCE_NS = 10,
    parameter int T_SD_NS  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          op_done,
    output logic [DW-1:0] op_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int RD_NS   = max2(max2(T_RC_NS, T_AA_NS), max2(T_ACE_NS, T_DOE_NS));
    localparam int WR_NS   = max2(max2(T_WC_NS, T_PWE_NS), max2(T_SCE_NS, T_SD_NS));
    localparam int RD_CYC  = ns_to_cycles(RD_NS, T_CLK_NS);
    localparam int WR_CYC  = ns_to_cycles(WR_NS, T_CLK_NS);
    localparam int MAX_CYC = max2(RD_CYC, WR_CYC);
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYC - 1);

    ctl_state_t    state_q, state_d;
    logic          last_rd_q;
    logic          accept;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    logic          rd_capture;

    assign accept = (state_q == ST_IDLE) && req_valid;

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    asram_req_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .in_addr   (req_addr),
        .in_wdata  (req_wdata),
        .out_addr  (mem_addr),
        .out_wdata (mem_dq_o)
    );

    asram_rdata_reg #(.DW(DW)) u_rdata (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .d       (mem_dq_i),
        .q       (op_rdata)
    );

    // Next-state and timer-load logic
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = WR_LOAD;
        rd_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_we) begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end else if (last_rd_q) begin
                        state_d  = ST_TURN;
                    end else begin
                        state_d  = ST_WR_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = WR_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_expired) begin
                    state_d    = ST_RD_RESP;
                    rd_capture = 1'b1;
                end
            end
            ST_RD_RESP:  state_d = ST_IDLE;
            ST_TURN: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WR_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_expired)
                    state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RD_RESP)
                last_rd_q <= 1'b1;
            else if (state_d == ST_WR_PULSE)
                last_rd_q <= 1'b0;
        end
    end

    // Output decode
    always_comb begin
        req_ready = 1'b0;
        op_done   = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_RD_ACC: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_RD_RESP:  op_done = 1'b1;
            ST_TURN:     ;
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_dq_oe = 1'b1;
                op_done   = 1'b1;
            end
            default:     ;
        endcase
    end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int AW = 18,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          op_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe
);
    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_we_n) |-> mem_oe_n);

    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r2_read_strobe_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_oe_n) |-> (mem_we_n && !mem_dq_oe));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !op_done));

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r3_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && $past(!mem_ce_n && !mem_we_n))
            |-> (mem_ce_n && mem_dq_oe && op_done && $stable(mem_addr) && $stable(mem_dq_o)));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .op_done   (op_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
    localparam int CLK_NS = 8;
    localparam int PWE_NS = 10;
    localparam int SD_NS  = 7;

    function automatic int ceil_cyc(input int t);
        int c;
        c = (t + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RD_N = ceil_cyc(12);
    localparam int WR_N = ceil_cyc(12);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, op_done;
    logic [3:0]  op_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_dq_o, mem_dq_i;

    int checks = 0;
    int errors = 0;
    bit last_rd = 1'b0;

    logic [3:0] model_mem [int];
    logic [3:0] ref_mem [int];

    always #(CLK_NS/2) clk = ~clk;

    asram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .op_done(op_done), .op_rdata(op_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic logic [3:0] init_word(input logic [17:0] a);
        return a[3:0] ^ a[11:8] ^ a[17:14] ^ 4'hA;
    endfunction

    function automatic logic [3:0] model_rd(input logic [17:0] a);
        if (model_mem.exists(int'(a))) return model_mem[int'(a)];
        return init_word(a);
    endfunction

    function automatic logic [3:0] ref_rd(input logic [17:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return init_word(a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // RAM model: drives only when selected for reading.
    always_comb mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model_rd(mem_addr) : 4'h0;

    wire wr_on = !mem_ce_n && !mem_we_n;
    realtime wr_start;
    always @(posedge wr_on) wr_start = $realtime;
    always @(negedge wr_on) begin
        model_mem[int'(mem_addr)] = mem_dq_o;
        check(($realtime - wr_start) >= PWE_NS && ($realtime - wr_start) >= SD_NS,
              "R3 write pulse width", int'($realtime - wr_start), PWE_NS);
        check(mem_dq_oe == 1'b1, "R3 data driven at write end", mem_dq_oe, 1);
    end

    task automatic do_op(input bit we, input logic [17:0] a, input logic [3:0] d,
                         input bit poke_busy);
        int lat;
        int exp_lat;
        bit turn;
        turn = we && last_rd;
        exp_lat = (we ? WR_N : RD_N) + 1 + (turn ? 1 : 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R6 ready in idle", req_ready, 1);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        lat = 1;
        if (poke_busy) begin
            req_we = 1'b1; req_addr = a ^ 18'h1; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        if (turn)
            check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R5 turnaround cycle",
                  {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        while (!op_done && lat < 20) begin
            if (req_ready) check(1'b0, "R6 ready while busy", 1, 0);
            if (mem_dq_oe && !mem_oe_n) check(1'b0, "R4 contention", 1, 0);
            if (wr_on && !mem_oe_n) check(1'b0, "R4 oe low in write", 0, 1);
            if (!mem_ce_n && mem_addr != a) check(1'b0, "R7 address held", int'(mem_addr), int'(a));
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        check(lat == exp_lat, we ? "R3 write latency" : "R2 read latency", lat, exp_lat);
        if (!we)
            check(op_rdata == ref_rd(a), "R2 read data", op_rdata, ref_rd(a));
        else
            ref_mem[int'(a)] = d;
        @(negedge clk);
        check(op_done == 1'b0, "R6 done single cycle", op_done, 0);
        last_rd = !we;
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        #3;
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !op_done && req_ready,
              "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, op_done, req_ready}, 6'b111001);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !op_done && req_ready,
              "R1 after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, op_done, req_ready}, 6'b111001);

        // R8 address range ends
        do_op(1'b1, 18'h00000, 4'h3, 1'b0);
        do_op(1'b1, 18'h3FFFF, 4'hC, 1'b0);
        do_op(1'b0, 18'h00000, 4'h0, 1'b0);
        do_op(1'b0, 18'h3FFFF, 4'h0, 1'b0);
        // R5 write directly after read
        do_op(1'b1, 18'h3FFFF, 4'h5, 1'b0);
        do_op(1'b0, 18'h3FFFF, 4'h0, 1'b0);
        // R6 requests during busy are ignored
        do_op(1'b1, 18'h00101, 4'h7, 1'b0);
        do_op(1'b0, 18'h00100, 4'h0, 1'b1);
        do_op(1'b1, 18'h00100, 4'h9, 1'b1);
        do_op(1'b0, 18'h00101, 4'h0, 1'b0);
        do_op(1'b0, 18'h00100, 4'h0, 1'b0);

        // Random traffic in a small address window to force read-backs
        for (int i = 0; i < 300; i++) begin
            logic [17:0] a;
            a = {$urandom} % 64;
            if ($urandom % 4 == 0) a = a | 18'h3FFC0;
            do_op($urandom % 2 == 1, a, 4'($urandom), $urandom % 8 == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule